// File: doc/BRIEF.md
# Circular Event Log Controller

This block manages one memory that is split into two regions. The lower addresses hold plain user data and the upper addresses hold a circular log of event entries, one memory word per entry. A 2-bit size code chooses the split in four steps of `UNIT` words. Software-visible pointer storage does not exist: the block keeps the oldest-entry, write, read and stream positions internally and moves them only in response to record requests and cursor commands.

A record request writes its word at the write position. Once the log holds its full capacity, every further record overwrites the oldest entry and the oldest-entry position moves up by one. Two independent cursors (read and stream) walk the log from oldest to newest. Writing a size code erases the whole memory with a zero sweep and then rebases every pointer. A separate user-access request port is answered with an acknowledge only when the address falls inside the user region.

The controller is a three-state machine. `ST_IDLE` serves records, cursor commands and user acknowledges. A size-code write in `ST_IDLE` moves it to `ST_ERASE`, which writes one zero word per cycle. When the last address has been written it moves to `ST_REBASE`, which loads the new code and clears the pointers. It then returns unconditionally to `ST_IDLE`. The memory port drives a synchronous RAM with one cycle of read latency.

Top module: `elog_ctrl`

## Requirements
- R1: After reset `busy`, `log_full`, `mem_we` and `rd_valid` are 0, `rd_empty` and `st_empty` are 1, and the size code is 00.
- R2: Size code c (0..3) gives a user region of c*UNIT words at addresses 0..c*UNIT-1 and an event capacity of (4-c)*UNIT entries at addresses c*UNIT..4*UNIT-1. Entry slot k sits at address c*UNIT+k.
- R3: `cfg_wr` in idle starts an erase on the next cycle, even if the code is unchanged. The erase drives `mem_we`=1 and `mem_wdata`=0 on addresses 0 to 4*UNIT-1, in ascending order, one per cycle. One rebase cycle follows with `mem_we`=0. `busy` is high for 4*UNIT+1 cycles. Afterwards all pointers and counts are zero and the new code is in force.
- R4: `rec_req` in idle drives `mem_we`=1 with `mem_wdata`=`rec_data` in the same cycle. The address is the event base plus the write slot. The write slot advances by one modulo the capacity.
- R5: `log_full` is 1 exactly when the stored count equals the capacity. A record made while full overwrites the oldest slot and advances the oldest position by one.
- R6: `cmd`=01 (read) while unread entries exist puts the read-cursor address on the port. On the next cycle `rd_valid`=1 and `rd_data` holds that entry. Entries come oldest first, and the cursor then advances.
- R7: `cmd`=10 (stream) behaves as R6 but uses a separate stream cursor that does not move the read cursor.
- R8: `cmd`=11 (rewind) returns both cursors to the oldest stored entry.
- R9: `rd_empty` (`st_empty`) is 1 when the read (stream) cursor has no unread entries. A read or stream command in that state is ignored: no memory access and no `rd_valid`.
- R10: While `busy`, the block ignores `rec_req`, `cmd` and `cfg_wr`, raises no `rd_valid` and holds `usr_ack` at 0.
- R11: `usr_ack` = `usr_req` and not busy and `usr_addr` < c*UNIT. It is never raised under code 00.
- R12: Priority in idle is `cfg_wr`, then `rec_req`, then `cmd`. A lower request in the same cycle is dropped.
- R13: Cursors count from the oldest entry. When an overwrite drops the oldest entry, a cursor that pointed at it moves to the new oldest entry. Any other cursor keeps pointing at the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write a new size code (starts erase) |
| cfg_code | input | 2 | Size code to apply |
| busy | output | 1 | Erase or rebase in progress |
| rec_req | input | 1 | Record one event |
| rec_data | input | DW | Event word to store |
| cmd | input | 2 | Cursor command: 00 none, 01 read, 10 stream, 11 rewind |
| rd_valid | output | 1 | Returned entry valid |
| rd_data | output | DW | Returned entry |
| rd_empty | output | 1 | Read cursor has nothing unread |
| st_empty | output | 1 | Stream cursor has nothing unread |
| log_full | output | 1 | Log holds its full capacity |
| usr_req | input | 1 | User-region access request |
| usr_addr | input | AW | User-region word address |
| usr_ack | output | 1 | User access accepted |
| mem_addr | output | AW | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data (one-cycle latency) |

## Verification
The hardest state to reach is an overwrite that lands while both cursors sit at different offsets inside a full log. The cursor adjustment of R13 must then be correct for a cursor at the oldest entry as well as for one further along. The bench gets there by consuming entries early with read and stream, then recording past capacity for every size code, and only afterwards draining both cursors against its own model of the circular store. Requests held high throughout the erase sweep, including a second size-code write in the middle of it, show that nothing leaks into the sweep.

// File: rtl/elog_pkg.sv
package elog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ERASE  = 2'd1,
        ST_REBASE = 2'd2
    } elog_state_e;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_READ   = 2'd1,
        CMD_STREAM = 2'd2,
        CMD_REWIND = 2'd3
    } elog_cmd_e;

    localparam int N_CURSORS = 2;

endpackage

// File: rtl/elog_cfg_map.sv
module elog_cfg_map #(
    parameter int UNIT = 1000,
    parameter int AW   = 12,
    parameter int CW   = 12
) (
    input  logic [1:0]    code,
    output logic [AW-1:0] base,
    output logic [CW-1:0] cap
);
    always_comb begin
        base = AW'(int'(code) * UNIT);
        cap  = CW'((4 - int'(code)) * UNIT);
    end
endmodule

// File: rtl/elog_ptrs.sv
module elog_ptrs #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rec,
    input  logic [CW-1:0] cap,
    output logic [CW-1:0] fp,
    output logic [CW-1:0] wp,
    output logic [CW-1:0] cnt,
    output logic          full
);
    logic [CW-1:0] fp_inc, wp_inc;

    always_comb begin
        full   = (cnt == cap);
        fp_inc = (fp + 1'b1 == cap) ? '0 : fp + 1'b1;
        wp_inc = (wp + 1'b1 == cap) ? '0 : wp + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else if (clr) begin
            fp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else if (rec) begin
            wp <= wp_inc;
            if (full) fp  <= fp_inc;
            else      cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/elog_cursor.sv
module elog_cursor #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rewind,
    input  logic          adv,
    input  logic          drop,
    output logic [CW-1:0] off
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off <= '0;
        end else if (clr || rewind) begin
            off <= '0;
        end else if (drop) begin
            if (off != '0) off <= off - 1'b1;
        end else if (adv) begin
            off <= off + 1'b1;
        end
    end
endmodule

// File: rtl/elog_ctrl.sv
module elog_ctrl
    import elog_pkg::*;
#(
    parameter int UNIT = 1000,
    parameter int DW   = 8,
    localparam int MEM_WORDS = 4 * UNIT,
    localparam int AW = $clog2(MEM_WORDS),
    localparam int CW = $clog2(MEM_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_code,
    output logic          busy,
    input  logic          rec_req,
    input  logic [DW-1:0] rec_data,
    input  logic [1:0]    cmd,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          rd_empty,
    output logic          st_empty,
    output logic          log_full,
    input  logic          usr_req,
    input  logic [AW-1:0] usr_addr,
    output logic          usr_ack,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    elog_state_e   state_q, state_d;
    logic [1:0]    code_q, pend_q;
    logic [AW-1:0] sweep_q;
    logic          rd_valid_q;

    logic [AW-1:0] base;
    logic [CW-1:0] cap, fp, wp, cnt;
    logic          full, clr, idle;
    logic          cfg_go, rec_go, rw_go;
    logic [N_CURSORS-1:0] cur_go, cur_empty;
    logic [CW-1:0] cur_off [N_CURSORS];
    logic [CW-1:0] cur_slot [N_CURSORS];
    elog_cmd_e     cmd_e;

    function automatic logic [CW-1:0] wrap_add(input logic [CW-1:0] a,
                                               input logic [CW-1:0] b,
                                               input logic [CW-1:0] m);
        logic [CW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, m}) s = s - {1'b0, m};
        return s[CW-1:0];
    endfunction

    elog_cfg_map #(.UNIT(UNIT), .AW(AW), .CW(CW)) u_map (
        .code (code_q),
        .base (base),
        .cap  (cap)
    );

    elog_ptrs #(.CW(CW)) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .rec   (rec_go),
        .cap   (cap),
        .fp    (fp),
        .wp    (wp),
        .cnt   (cnt),
        .full  (full)
    );

    // Request decode: size write beats record beats cursor command.
    always_comb begin
        cmd_e  = elog_cmd_e'(cmd);
        idle   = (state_q == ST_IDLE);
        clr    = (state_q == ST_REBASE);
        cfg_go = idle && cfg_wr;
        rec_go = idle && !cfg_wr && rec_req;
        rw_go  = idle && !cfg_wr && !rec_req && (cmd_e == CMD_REWIND);
        cur_go[0] = idle && !cfg_wr && !rec_req && (cmd_e == CMD_READ)   && !cur_empty[0];
        cur_go[1] = idle && !cfg_wr && !rec_req && (cmd_e == CMD_STREAM) && !cur_empty[1];
    end

    for (genvar g = 0; g < N_CURSORS; g++) begin : g_cur
        elog_cursor #(.CW(CW)) u_cur (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .rewind (rw_go),
            .adv    (cur_go[g]),
            .drop   (rec_go && full),
            .off    (cur_off[g])
        );
        assign cur_empty[g] = (cur_off[g] == cnt);
        assign cur_slot[g]  = wrap_add(fp, cur_off[g], cap);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cfg_wr) state_d = ST_ERASE;
            ST_ERASE:  if (sweep_q == AW'(MEM_WORDS - 1)) state_d = ST_REBASE;
            ST_REBASE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q     <= 2'b00;
            pend_q     <= 2'b00;
            sweep_q    <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= |cur_go;
            if (cfg_go) begin
                pend_q  <= cfg_code;
                sweep_q <= '0;
            end else if (state_q == ST_ERASE) begin
                sweep_q <= sweep_q + 1'b1;
            end
            if (clr) code_q <= pend_q;
        end
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_ERASE: begin
                busy     = 1'b1;
                mem_we   = 1'b1;
                mem_addr = sweep_q;
            end
            ST_REBASE: begin
                busy = 1'b1;
            end
            ST_IDLE: begin
                if (rec_go) begin
                    mem_we    = 1'b1;
                    mem_addr  = base + AW'(wp);
                    mem_wdata = rec_data;
                end else if (cur_go[0]) begin
                    mem_addr = base + AW'(cur_slot[0]);
                end else if (cur_go[1]) begin
                    mem_addr = base + AW'(cur_slot[1]);
                end
            end
            default: busy = 1'b1;
        endcase
        rd_valid = rd_valid_q;
        rd_data  = rd_valid_q ? mem_rdata : '0;
        rd_empty = cur_empty[0];
        st_empty = cur_empty[1];
        log_full = full;
        usr_ack  = usr_req && idle && (usr_addr < base);
    end
endmodule

// File: rtl/elog_ctrl_chk.sv
module elog_ctrl_chk #(
    parameter int UNIT = 1000,
    parameter int DW   = 8,
    localparam int MEM_WORDS = 4 * UNIT,
    localparam int AW = $clog2(MEM_WORDS),
    localparam int CW = $clog2(MEM_WORDS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          cfg_wr,
    input logic          rec_req,
    input logic [1:0]    cmd,
    input logic          rd_valid,
    input logic          rd_empty,
    input logic          usr_ack,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic [1:0]    code,
    input logic [CW-1:0] fp,
    input logic [CW-1:0] wp,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] cap
);
    logic [CW:0]   wsum;
    logic [CW-1:0] wp_exp;
    always_comb begin
        wsum   = {1'b0, fp} + {1'b0, cnt};
        wp_exp = (wsum >= {1'b0, cap}) ? CW'(wsum - {1'b0, cap}) : CW'(wsum);
    end

    a_r3_erase_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_we) |-> (mem_wdata == '0));

    a_r3_sweep_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_we && mem_addr == '0));

    a_r3_sweep_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_we && $past(busy && mem_we)) |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

    a_r10_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !usr_ack);

    a_r10_busy_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !rd_valid);

    a_r11_no_user_code0: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 2'b00) |-> !usr_ack);

    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cnt <= cap));

    a_r4_wp_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (wp == wp_exp));

    a_r9_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg_wr && !rec_req && cmd == 2'b01 && rd_empty) |=> !rd_valid);
endmodule

bind elog_ctrl elog_ctrl_chk #(.UNIT(UNIT), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .cfg_wr    (cfg_wr),
    .rec_req   (rec_req),
    .cmd       (cmd),
    .rd_valid  (rd_valid),
    .rd_empty  (rd_empty),
    .usr_ack   (usr_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .code      (code_q),
    .fp        (fp),
    .wp        (wp),
    .cnt       (cnt),
    .cap       (cap)
);

// File: tb/tb_elog_ctrl.sv
`timescale 1ns/1ps
module tb_elog_ctrl;
    localparam int UNIT = 4;
    localparam int DW   = 8;
    localparam int MEM  = 4 * UNIT;
    localparam int AW   = $clog2(MEM);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_code = 2'b00;
    logic          busy;
    logic          rec_req = 1'b0;
    logic [DW-1:0] rec_data = '0;
    logic [1:0]    cmd = 2'b00;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          rd_empty, st_empty, log_full;
    logic          usr_req = 1'b0;
    logic [AW-1:0] usr_addr = '0;
    logic          usr_ack;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    always #4 clk = ~clk;

    elog_ctrl #(.UNIT(UNIT), .DW(DW)) dut (.*);

    logic [DW-1:0] ram [MEM];
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    int total = 0, bad = 0;
    int m_cap = MEM, m_base = 0, m_fp = 0, m_cnt = 0, m_rd = 0, m_sp = 0, seq = 0;
    logic [DW-1:0] hist [MEM];

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_flags();
        chk("R5 log_full", int'(log_full), int'(m_cnt == m_cap));
        chk("R9 rd_empty", int'(rd_empty), int'(m_rd == m_cnt));
        chk("R9 st_empty", int'(st_empty), int'(m_sp == m_cnt));
    endtask

    task automatic do_cfg(int c);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_code = 2'(c);
        @(negedge clk);
        cfg_wr = 1'b0; rec_req = 1'b1; rec_data = 8'hA5; cmd = 2'b01;
        usr_req = 1'b1; usr_addr = '0;
        for (int i = 0; i < MEM; i++) begin
            #1;
            chk("R3 busy in sweep", int'(busy), 1);
            chk("R3 sweep we", int'(mem_we), 1);
            chk("R3 sweep addr", int'(mem_addr), i);
            chk("R10 sweep data zero (record dropped)", int'(mem_wdata), 0);
            chk("R10 no ack while busy", int'(usr_ack), 0);
            chk("R10 no rd_valid while busy", int'(rd_valid), 0);
            if (i == 5) begin cfg_wr = 1'b1; cfg_code = 2'(c ^ 1); end
            @(negedge clk);
            cfg_wr = 1'b0;
        end
        #1;
        chk("R3 rebase busy", int'(busy), 1);
        chk("R3 rebase no write", int'(mem_we), 0);
        @(negedge clk);
        rec_req = 1'b0; cmd = 2'b00; usr_req = 1'b0;
        #1;
        chk("R3 busy released", int'(busy), 0);
        m_cap = (4 - c) * UNIT; m_base = c * UNIT;
        m_fp = 0; m_cnt = 0; m_rd = 0; m_sp = 0;
        for (int a = 0; a < MEM; a++) chk("R3 memory zeroed", int'(ram[a]), 0);
        chk_flags();
    endtask

    task automatic do_rec();
        int slot;
        seq++;
        @(negedge clk);
        rec_req = 1'b1; rec_data = DW'(seq * 13 + 5);
        #1;
        slot = (m_fp + m_cnt) % m_cap;
        chk("R4 record we", int'(mem_we), 1);
        chk("R2 R4 record addr", int'(mem_addr), m_base + slot);
        chk("R4 record data", int'(mem_wdata), int'(rec_data));
        hist[slot] = rec_data;
        if (m_cnt == m_cap) begin
            m_fp = (m_fp + 1) % m_cap;
            if (m_rd > 0) m_rd--;
            if (m_sp > 0) m_sp--;
        end else m_cnt++;
        @(negedge clk);
        rec_req = 1'b0;
        #1;
        chk_flags();
    endtask

    // k: 1 read, 2 stream, 3 rewind
    task automatic do_cmd(int k);
        int off, slot;
        bit go;
        off = (k == 1) ? m_rd : m_sp;
        go = (k != 3) && (off < m_cnt);
        slot = (m_fp + off) % m_cap;
        @(negedge clk);
        cmd = 2'(k);
        #1;
        if (go) begin
            chk("R6 R7 no write on read", int'(mem_we), 0);
            chk("R6 R7 read addr", int'(mem_addr), m_base + slot);
        end
        @(negedge clk);
        cmd = 2'b00;
        #1;
        if (k == 3) begin
            m_rd = 0; m_sp = 0;
            chk("R8 rewind no valid", int'(rd_valid), 0);
        end else if (go) begin
            chk("R6 R7 rd_valid", int'(rd_valid), 1);
            chk("R6 R7 R13 rd_data", int'(rd_data), int'(hist[slot]));
            if (k == 1) m_rd++; else m_sp++;
        end else begin
            chk("R9 empty command ignored", int'(rd_valid), 0);
        end
        chk_flags();
    endtask

    task automatic do_collide();
        seq++;
        @(negedge clk);
        rec_req = 1'b1; rec_data = DW'(seq * 13 + 5); cmd = 2'b01;
        #1;
        chk("R12 record wins we", int'(mem_we), 1);
        chk("R12 record wins data", int'(mem_wdata), int'(rec_data));
        hist[(m_fp + m_cnt) % m_cap] = rec_data;
        if (m_cnt == m_cap) begin
            m_fp = (m_fp + 1) % m_cap;
            if (m_rd > 0) m_rd--;
            if (m_sp > 0) m_sp--;
        end else m_cnt++;
        @(negedge clk);
        rec_req = 1'b0; cmd = 2'b00;
        #1;
        chk("R12 command dropped", int'(rd_valid), 0);
        chk_flags();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < MEM; a++) ram[a] = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 busy", int'(busy), 0);
        chk("R1 log_full", int'(log_full), 0);
        chk("R1 mem_we", int'(mem_we), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 rd_empty", int'(rd_empty), 1);
        chk("R1 st_empty", int'(st_empty), 1);
        @(negedge clk);
        rst_n = 1'b1;
        // Reset code 00: full-size log, no user space
        for (int n = 0; n < MEM + 1; n++) do_rec();
        do_cmd(1);
        chk("R1 R2 default capacity", m_cap, MEM);

        for (int c = 3; c >= 0; c--) begin
            do_cfg(c);
            for (int a = 0; a < MEM; a++) begin
                @(negedge clk);
                usr_req = 1'b1; usr_addr = AW'(a);
                #1;
                chk("R11 R2 user ack", int'(usr_ack), int'(a < c * UNIT));
            end
            @(negedge clk);
            usr_req = 1'b0;
            do_cmd(1);                       // empty read
            do_cmd(2);                       // empty stream
            do_rec(); do_rec();
            do_cmd(1);                       // read cursor to offset 1
            do_collide();
            for (int n = 0; n < m_cap + 2; n++) do_rec();  // overflow
            do_cmd(2); do_cmd(2);
            while (m_rd < m_cnt) do_cmd(1);
            do_cmd(1);                       // one past the end
            do_rec();                        // overwrite with cursors placed
            do_cmd(3);
            do_cmd(1);
            do_cmd(2); do_cmd(2);
            chk("R5 full after overflow", int'(log_full), 1);
        end
        do_cfg(0);
        do_cfg(0);                           // same code still erases
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule